// File: doc/BRIEF.md
# Host Symbol Data Port

This block sits between a host controller and the data path of a narrow-band FSK modem. It owns three pins: a data clock pin, a data pin and a clock-out pin. Each pin is modelled as an output value, an output enable and, where the pin can be an input, an input value. In the default host mode the block drives the data clock at the bit rate. While transmitting, it latches the host's bit from the data pin on the rising edge of that clock. While receiving, it drives recovered bits onto the data pin so that the clock rises in the middle of each bit.

Two other host modes swap the pin roles. In the asynchronous mode, transmit bits arrive on the data clock pin and received bits leave on the data pin, and whichever of the two is unused floats. The host times the bits itself. The clocked serial variant adds the bit clock on the clock-out pin. In four-level operation each symbol crosses the port as two bit slots, high bit first and low bit second. A sync-found pulse realigns the slot counter. A request to change direction waits for the next bit boundary. All pins float for one system clock before the new direction takes over.

The bit period is `BIT_DIV` system clocks. While receiving, the recovered bit strobe from the clock recovery logic restarts the bit timer, so that each strobe opens a new bit.

Top module: `dport_sym_port`

## Requirements
- R1: After reset the port receives in the default host mode. The data clock pin is driven low, the data pin is driven low, the clock-out pin is released and no transmit symbol is flagged.
- R2: When no strobe arrives, the bit clock has a period of BIT_DIV system clocks. It is low for the first BIT_DIV/2 clocks of each bit and high for the rest.
- R3: In default-mode transmit, the data clock pin is driven and the data pin is released. The data pin is sampled in the first cycle of the clock's high half. One cycle later `tx_sym_vld` pulses for one cycle with `tx_sym` = {0, bit} in two-level operation.
- R4: While receiving, a cycle with `rx_strobe` high drives the selected bit onto the data pin from the next cycle. The bit clock is low in that cycle and first goes high BIT_DIV/2 cycles later. In two-level operation the selected bit is `rx_sym[0]`.
- R5: The asynchronous host mode is selected by `uart_en`=1 with `clk_route` other than 7. In that mode, transmit releases the data clock, data and clock-out pins and takes each bit from `dclk_i`. `dat_i` is ignored.
- R6: In either non-default host mode, receive drives the data pin and releases the data clock pin.
- R7: The clock-out pin is driven with the bit clock only when `uart_en`=1 and `clk_route`=7. In all other configurations it is released.
- R8: In four-level transmit (`four_lvl`=1), the first sampled bit is held as the symbol's high bit without a valid pulse. The second produces `tx_sym_vld` with `tx_sym` = {first, second}.
- R9: In four-level receive, successive strobes drive `rx_sym[1]` and then `rx_sym[0]`.
- R10: A `sync_found` pulse makes the next bit slot, in either direction, the high bit of a symbol.
- R11: A change of `tx_req` takes effect at the next bit boundary. That boundary is a timer wrap or, while receiving, a strobe. Exactly one system clock follows with all three output enables low, and the pins then take the new direction's roles.
- R12: `tx_sym_vld` never pulses while the port is receiving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uart_en | input | 1 | Selects a non-default host mode |
| clk_route | input | 3 | Clock routing field; 7 with uart_en selects the clocked serial mode |
| four_lvl | input | 1 | Two bit slots per symbol |
| tx_req | input | 1 | Requested direction, 1 = transmit |
| rx_strobe | input | 1 | Recovered bit strobe from clock recovery |
| rx_sym | input | 2 | Received symbol from the demodulator |
| sync_found | input | 1 | Sync word found pulse |
| dclk_i | input | 1 | Data clock pin input value |
| dclk_o | output | 1 | Data clock pin output value |
| dclk_oe | output | 1 | Data clock pin drive enable |
| dat_i | input | 1 | Data pin input value |
| dat_o | output | 1 | Data pin output value |
| dat_oe | output | 1 | Data pin drive enable |
| ckout_o | output | 1 | Clock-out pin output value |
| ckout_oe | output | 1 | Clock-out pin drive enable |
| tx_sym | output | 2 | Assembled transmit symbol |
| tx_sym_vld | output | 1 | One-cycle valid for tx_sym |

## Verification
A wrong slot phase shows at once as swapped bit halves. In receive, the wrong half of `rx_sym` reaches the data pin in the cycle after the strobe. In transmit, a symbol is assembled from bits belonging to two different symbols, visible at the next valid pulse. A timer that has lost its phase shows within one bit period, because the first high cycle no longer falls BIT_DIV/2 cycles after a strobe. A direction register that is stuck or switches early shows as output enables that never go quiet, or as a quiet gap other than one cycle, within one bit period of the request.

// File: rtl/dport_pkg.sv
package dport_pkg;

  typedef enum logic [1:0] {
    HM_STD  = 2'd0,
    HM_UART = 2'd1,
    HM_SPI  = 2'd2
  } host_mode_e;

  localparam logic [2:0] SPI_ROUTE = 3'd7;

  // Host mode decode from the enable bit and the clock routing field.
  function automatic host_mode_e host_mode_of(input logic uart, input logic [2:0] route);
    if (!uart) return HM_STD;
    else if (route == SPI_ROUTE) return HM_SPI;
    else return HM_UART;
  endfunction

  // Bit of a received symbol that belongs to the current slot.
  function automatic logic slot_bit(input logic [1:0] sym, input logic four, input logic lsb);
    if (!four) return sym[0];
    else return lsb ? sym[0] : sym[1];
  endfunction

endpackage

// File: rtl/dport_bit_timer.sv
module dport_bit_timer #(
  parameter int BIT_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic bclk,
  output logic rise_ev,
  output logic bound_ev
);
  localparam int CW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(BIT_DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(BIT_DIV / 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (restart)       cnt <= '0;
    else if (cnt == LAST_C) cnt <= '0;
    else                    cnt <= cnt + CW'(1);
  end

  assign bclk     = (cnt >= HALF_C);
  assign rise_ev  = (cnt == HALF_C);
  assign bound_ev = restart || (cnt == LAST_C);

  // R2
  rise_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |-> $past(!bclk));

  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

endmodule

// File: rtl/dport_sym_slot.sv
module dport_sym_slot
  import dport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       four_lvl,
  input  logic       clr,
  input  logic       tx_take,
  input  logic       tx_bit,
  input  logic       rx_take,
  input  logic [1:0] rx_sym,
  output logic [1:0] tx_sym,
  output logic       tx_vld,
  output logic       rx_bit
);
  logic lsb_slot;
  logic msb_hold;
  logic take_any;

  assign take_any = tx_take || rx_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_slot <= 1'b0;
      msb_hold <= 1'b0;
      tx_sym   <= 2'b00;
      tx_vld   <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      tx_vld <= 1'b0;
      if (tx_take) begin
        if (four_lvl && !lsb_slot) begin
          msb_hold <= tx_bit;
        end else begin
          tx_sym <= four_lvl ? {msb_hold, tx_bit} : {1'b0, tx_bit};
          tx_vld <= 1'b1;
        end
      end
      if (rx_take) rx_bit <= slot_bit(rx_sym, four_lvl, lsb_slot);
      if (clr)                       lsb_slot <= 1'b0;
      else if (!four_lvl)            lsb_slot <= 1'b0;
      else if (take_any)             lsb_slot <= !lsb_slot;
    end
  end

  // R3
  vld_from_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> $past(tx_take));

  // R10
  sync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !lsb_slot);

endmodule

// File: rtl/dport_pin_mux.sv
module dport_pin_mux
  import dport_pkg::*;
(
  input  host_mode_e hm,
  input  logic       cur_tx,
  input  logic       gap,
  input  logic       bclk,
  input  logic       rx_bit,
  output logic       dclk_o,
  output logic       dclk_oe,
  output logic       dat_o,
  output logic       dat_oe,
  output logic       ckout_o,
  output logic       ckout_oe
);
  always_comb begin
    dclk_o   = 1'b0;
    dclk_oe  = 1'b0;
    dat_o    = 1'b0;
    dat_oe   = 1'b0;
    ckout_o  = 1'b0;
    ckout_oe = 1'b0;
    if (!gap) begin
      if (!cur_tx) begin
        dat_oe = 1'b1;
        dat_o  = rx_bit;
      end
      if (hm == HM_STD) begin
        dclk_oe = 1'b1;
        dclk_o  = bclk;
      end else if (hm == HM_SPI) begin
        ckout_oe = 1'b1;
        ckout_o  = bclk;
      end
    end
  end
endmodule

// File: rtl/dport_sym_port.sv
module dport_sym_port
  import dport_pkg::*;
#(
  parameter int BIT_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uart_en,
  input  logic [2:0] clk_route,
  input  logic       four_lvl,
  input  logic       tx_req,
  input  logic       rx_strobe,
  input  logic [1:0] rx_sym,
  input  logic       sync_found,
  input  logic       dclk_i,
  output logic       dclk_o,
  output logic       dclk_oe,
  input  logic       dat_i,
  output logic       dat_o,
  output logic       dat_oe,
  output logic       ckout_o,
  output logic       ckout_oe,
  output logic [1:0] tx_sym,
  output logic       tx_sym_vld
);
  host_mode_e hm;
  logic cur_tx, gap;
  logic bclk, rise_ev, bound_ev;
  logic restart, switch_ev, clr;
  logic tx_take, rx_take, tx_bit, rx_bit;

  assign hm        = host_mode_of(uart_en, clk_route);
  assign restart   = rx_strobe && !cur_tx;
  assign switch_ev = bound_ev && (tx_req != cur_tx);
  assign clr       = sync_found || switch_ev;
  assign tx_take   = rise_ev && cur_tx && !gap;
  assign rx_take   = rx_strobe && !cur_tx && !gap;
  assign tx_bit    = (hm == HM_STD) ? dat_i : dclk_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_tx <= 1'b0;
      gap    <= 1'b0;
    end else begin
      gap <= switch_ev;
      if (switch_ev) cur_tx <= tx_req;
    end
  end

  dport_bit_timer #(.BIT_DIV(BIT_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .bclk(bclk), .rise_ev(rise_ev), .bound_ev(bound_ev)
  );

  dport_sym_slot u_slot (
    .clk(clk), .rst_n(rst_n), .four_lvl(four_lvl), .clr(clr),
    .tx_take(tx_take), .tx_bit(tx_bit), .rx_take(rx_take), .rx_sym(rx_sym),
    .tx_sym(tx_sym), .tx_vld(tx_sym_vld), .rx_bit(rx_bit)
  );

  dport_pin_mux u_mux (
    .hm(hm), .cur_tx(cur_tx), .gap(gap), .bclk(bclk), .rx_bit(rx_bit),
    .dclk_o(dclk_o), .dclk_oe(dclk_oe), .dat_o(dat_o), .dat_oe(dat_oe),
    .ckout_o(ckout_o), .ckout_oe(ckout_oe)
  );

  // R11
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_ev |=> !(dclk_oe || dat_oe || ckout_oe));

  // R12
  vld_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym_vld |-> cur_tx);

  // R6
  host_clk_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uart_en |-> !dclk_oe);

  // R7
  ckout_spi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckout_oe |-> (uart_en && clk_route == 3'd7));

endmodule

// File: tb/sim_dport_sym_port.sv
module sim_dport_sym_port;
  localparam int CLK_PERIOD = 10;
  localparam int BD   = 8;
  localparam int HALF = BD / 2;

  logic clk = 1'b0;
  logic rst_n;
  logic uart_en, four_lvl, tx_req, rx_strobe, sync_found, dclk_i, dat_i;
  logic [2:0] clk_route;
  logic [1:0] rx_sym;
  logic dclk_o, dclk_oe, dat_o, dat_oe, ckout_o, ckout_oe, tx_sym_vld;
  logic [1:0] tx_sym;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dport_sym_port #(.BIT_DIV(BD)) u0 (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .clk_route(clk_route),
    .four_lvl(four_lvl), .tx_req(tx_req), .rx_strobe(rx_strobe), .rx_sym(rx_sym),
    .sync_found(sync_found), .dclk_i(dclk_i), .dclk_o(dclk_o), .dclk_oe(dclk_oe),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe), .ckout_o(ckout_o),
    .ckout_oe(ckout_oe), .tx_sym(tx_sym), .tx_sym_vld(tx_sym_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_found = 1'b1;
    @(negedge clk); sync_found = 1'b0;
  endtask

  // clk_sel: 0 = data clock pin, 1 = clock-out pin, 2 = no clock check
  task automatic strobe_chk(input logic [1:0] sym, input logic expb, input int clk_sel, input string req);
    logic cv;
    @(negedge clk); rx_sym = sym; rx_strobe = 1'b1;
    @(negedge clk); rx_strobe = 1'b0;
    chk(dat_oe && dat_o == expb, req, int'(dat_o), int'(expb));
    cv = (clk_sel == 1) ? ckout_o : dclk_o;
    if (clk_sel != 2) chk(cv == 1'b0, "R4 clock low after strobe", int'(cv), 0);
    for (int i = 2; i <= BD; i++) begin
      @(negedge clk);
      cv = (clk_sel == 1) ? ckout_o : dclk_o;
      if (clk_sel != 2 && i == HALF)     chk(cv == 1'b0, "R4 clock still low", int'(cv), 0);
      if (clk_sel != 2 && i == HALF + 1) chk(cv == 1'b1, "R4 clock rises mid bit", int'(cv), 1);
    end
  endtask

  task automatic do_switch(input logic to_tx);
    int quiet;
    quiet = 0;
    @(negedge clk); tx_req = to_tx;
    for (int i = 0; i < BD + 4; i++) begin
      @(negedge clk);
      if (!dclk_oe && !dat_oe && !ckout_oe) quiet++;
    end
    chk(quiet == 1, "R11 one quiet cycle", quiet, 1);
  endtask

  task automatic wait_rise();
    logic prev;
    prev = dclk_o;
    for (int i = 0; i < 3 * BD; i++) begin
      @(negedge clk);
      if (!prev && dclk_o) break;
      prev = dclk_o;
    end
  endtask

  task automatic wait_vld(output bit got);
    got = 0;
    for (int i = 0; i < 3 * BD; i++) begin
      @(negedge clk);
      if (tx_sym_vld) begin got = 1; break; end
    end
  endtask

  task automatic tx_bit_chk(input logic b, input bit via_clk_pin, input string req);
    bit got;
    @(negedge clk);
    if (via_clk_pin) begin dclk_i = b; dat_i = !b; end
    else begin dat_i = b; dclk_i = !b; end
    wait_vld(got);
    chk(got && tx_sym == {1'b0, b}, req, int'(tx_sym), int'(b));
    if (!via_clk_pin) chk(dclk_o && !dat_oe, "R3 sampled in high half", int'(dclk_o), 1);
  endtask

  task automatic tx_sym_chk(input logic [1:0] s, input string req);
    bit got;
    @(negedge clk); dat_i = s[1];
    wait_rise();
    @(negedge clk);
    chk(!tx_sym_vld, "R8 no valid after high bit", int'(tx_sym_vld), 0);
    dat_i = s[0];
    wait_vld(got);
    chk(got && tx_sym == s, req, int'(tx_sym), int'(s));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, vlds;
    rst_n = 1'b0; uart_en = 1'b0; clk_route = 3'd0; four_lvl = 1'b0;
    tx_req = 1'b0; rx_strobe = 1'b0; rx_sym = 2'b00; sync_found = 1'b0;
    dclk_i = 1'b0; dat_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dclk_oe && !dclk_o, "R1 data clock driven low", int'(dclk_oe), 1);
    chk(dat_oe && !dat_o, "R1 data pin driven low", int'(dat_oe), 1);
    chk(!ckout_oe && !tx_sym_vld, "R1 clock-out released", int'(ckout_oe), 0);

    // R2 free-running bit clock shape
    wait_rise();
    hi = 1; lo = 0;
    for (int i = 0; i < 2 * BD; i++) begin
      @(negedge clk);
      if (dclk_o && lo == 0) hi++;
      else if (!dclk_o) lo++;
      else break;
    end
    chk(hi == BD - HALF, "R2 high half length", hi, BD - HALF);
    chk(lo == HALF, "R2 low half length", lo, HALF);

    // R4 two-level receive sweep
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s;
      s = 2'(i * 3 + 1);
      strobe_chk(s, s[0], 0, "R4 rx bit");
    end

    // R9 four-level receive, high slot then low slot
    four_lvl = 1'b1;
    pulse_sync();
    for (int s = 0; s < 4; s++) begin
      strobe_chk(2'(s), 1'(s >> 1), 0, "R9 rx high slot");
      strobe_chk(2'(s), 1'(s & 1), 0, "R9 rx low slot");
    end
    // R10 sync realigns receive
    strobe_chk(2'b10, 1'b1, 0, "R9 rx high slot");
    pulse_sync();
    strobe_chk(2'b01, 1'b0, 0, "R10 rx slot after sync");
    four_lvl = 1'b0;

    // R11 switch to transmit
    do_switch(1'b1);
    chk(dclk_oe && !dat_oe, "R3 tx pin roles", int'(dat_oe), 0);

    // R3 two-level transmit
    for (int i = 0; i < 8; i++) tx_bit_chk(1'((i * 5 >> 1) & 1), 1'b0, "R3 tx symbol");

    // R8 four-level transmit
    four_lvl = 1'b1;
    wait_rise();
    @(negedge clk);
    pulse_sync();
    for (int s = 0; s < 4; s++) tx_sym_chk(2'(3 - s), "R8 tx symbol");
    // R10 sync realigns transmit
    @(negedge clk); dat_i = 1'b1;
    wait_rise();
    @(negedge clk);
    pulse_sync();
    tx_sym_chk(2'b01, "R10 tx symbol after sync");
    four_lvl = 1'b0;

    // R5 asynchronous transmit: bits via data clock pin
    @(negedge clk); uart_en = 1'b1; clk_route = 3'd0;
    @(negedge clk);
    chk(!dclk_oe && !dat_oe && !ckout_oe, "R5 all pins released", int'(dclk_oe | dat_oe | ckout_oe), 0);
    for (int i = 0; i < 6; i++) tx_bit_chk(1'(i & 1), 1'b1, "R5 tx bit from clock pin");

    // R7 clocked serial transmit drives clock-out
    @(negedge clk); clk_route = 3'd7;
    @(negedge clk);
    chk(ckout_oe && !dclk_oe && !dat_oe, "R7 clock-out driven", int'(ckout_oe), 1);

    // R11 back to receive in clocked serial mode
    do_switch(1'b0);
    chk(dat_oe && !dclk_oe && ckout_oe, "R6 rx pin roles", int'(dclk_oe), 0);
    for (int i = 0; i < 4; i++) strobe_chk(2'(i), 1'(i & 1), 1, "R6 rx bit on data pin");

    // R7 other routing value releases clock-out
    @(negedge clk); clk_route = 3'd3;
    @(negedge clk);
    chk(!ckout_oe && !dclk_oe && dat_oe, "R7 clock-out released", int'(ckout_oe), 0);
    strobe_chk(2'b01, 1'b1, 2, "R6 rx bit asynchronous mode");

    // R12 no valid while receiving
    vlds = 0;
    for (int i = 0; i < 3 * BD; i++) begin
      @(negedge clk); dat_i = 1'(i & 1); dclk_i = 1'(i >> 1);
      if (tx_sym_vld) vlds++;
    end
    chk(vlds == 0, "R12 no valid in receive", vlds, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule